// File: doc/BRIEF.md
# Complex Twiddle Multiplier (sign-magnitude fixed point)

This block multiplies one complex sample by one complex rotation coefficient in a single combinational step. It sits between the data path and the butterfly stage of a transform engine. Each sample part is a 17-bit sign-and-magnitude word. Each coefficient part is a 9-bit sign-and-magnitude fraction whose magnitude is always below one.

A sample part holds its sign in bit 16, eight fraction bits in bits 15..8 and eight integer bits in bits 7..0. The block treats {bits 7..0, bits 15..8} as a 16-bit magnitude with 8 fractional bits. It forms the four partial products, truncates each one toward zero to the sample's scale, and combines them into a real result and an imaginary result. The results are repacked into the same 17-bit layout. There is no clock, no register and no coefficient storage.

Top module: `cmtw_twiddle_mul`

## Requirements
- R1: `y_re` equals the packed form of P(x_re,w_re) − P(x_im,w_im). Here P(a,b) = (signed value of a × signed value of b) / 256, truncated toward zero. The signed value of a sample part is ±(bits7..0 × 256 + bits15..8), and the signed value of a coefficient part is ±bits7..0. Bit 16 and bit 8 respectively set to 1 mean negative.
- R2: `y_im` equals the packed form of P(x_re,w_im) + P(x_im,w_re), with P as in R1.
- R3: Each partial product is truncated toward zero on its own before the sum is formed. Two products of 255/256 each, with opposite signs, therefore give 0. A negative product of magnitude 1.5 LSB gives −1 LSB.
- R4: A result of signed value v is packed as bit 16 = (v < 0), bits 15..8 = |v| mod 256 and bits 7..0 = |v| / 256. For example, 3.5 × 0.5 gives 17'h0C001.
- R5: An output whose magnitude is zero always has bit 16 cleared.
- R6: A coefficient with both magnitudes zero gives two all-zero outputs, whatever the sign bits of the coefficient.
- R7: Inverting the sign bits of both sample parts inverts the sign bit of each nonzero output and leaves its magnitude unchanged.
- R8: The outputs follow any input change without a clock edge.
- R9: A result magnitude beyond 16 bits keeps only its low 16 bits, and the sign is still that of the full result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_re | input | 17 | Sample real part, sign-magnitude, fraction above integer |
| x_im | input | 17 | Sample imaginary part, same layout |
| w_re | input | 9 | Coefficient real part, sign in bit 8, fraction in bits 7..0 |
| w_im | input | 9 | Coefficient imaginary part, same layout |
| y_re | output | 17 | Product real part, sample layout |
| y_im | output | 17 | Product imaginary part, sample layout |

## Verification
The bound checker watches several properties on every input change. No partial product may exceed its sample magnitude, because the coefficient is below one. Neither output may be a negative zero. A zero coefficient or a zero sample must give zero outputs. The exact arithmetic can only be shown by the bench's sweeps against its own integer model: the per-product truncation, the field order in the packed result, sign symmetry and magnitude wrap-around. These sweeps cover every coefficient code against many sample values, plus hand-picked truncation and layout cases.

// File: rtl/cmtw_pkg.sv
`timescale 1ns/1ps
package cmtw_pkg;
  // Default geometry of the sample and coefficient words.
  localparam int unsigned CMTW_DATA_W = 17;  // sign + 16 magnitude bits
  localparam int unsigned CMTW_TW_W   = 9;   // sign + 8 fraction bits
  localparam int unsigned CMTW_INT_W  = 8;   // integer bits in the low end of a sample part
endpackage

// File: rtl/cmtw_part_decode.sv
`timescale 1ns/1ps
// Splits one sign-magnitude part into its sign flag and a plain magnitude.
// INT_W > 0: the integer field sits below the fraction field, so the two are swapped.
// INT_W == 0: the part is a pure fraction and the magnitude is taken as is.
module cmtw_part_decode #(
  parameter int unsigned W     = 17,
  parameter int unsigned INT_W = 8
) (
  input  logic [W-1:0] code,
  output logic         neg,
  output logic [W-2:0] mag
);
  localparam int unsigned MW = W - 1;

  assign neg = code[W-1];

  generate
    if (INT_W == 0) begin : g_pure_frac
      assign mag = code[MW-1:0];
    end else begin : g_swapped
      localparam int unsigned FR = MW - INT_W;
      assign mag = {code[INT_W-1:0], code[MW-1:INT_W]};
      initial begin
        if (FR == 0) $display("cmtw_part_decode: sample part has no fraction field");
      end
    end
  endgenerate
endmodule

// File: rtl/cmtw_smul.sv
`timescale 1ns/1ps
// One sign-magnitude partial product, rescaled by dropping the coefficient fraction.
// The magnitude is truncated, which for a sign-magnitude value is truncation toward zero.
module cmtw_smul #(
  parameter int unsigned MW = 16,   // sample magnitude width
  parameter int unsigned TW = 8     // coefficient magnitude width (all fraction)
) (
  input  logic          a_neg,
  input  logic [MW-1:0] a_mag,
  input  logic          b_neg,
  input  logic [TW-1:0] b_mag,
  output logic          p_neg,
  output logic [MW-1:0] p_mag
);
  localparam int unsigned PW = MW + TW;

  function automatic logic [MW-1:0] scaled_mag(input logic [MW-1:0] a, input logic [TW-1:0] b);
    logic [PW-1:0] full;
    full = PW'(a) * PW'(b);
    return MW'(full >> TW);
  endfunction

  assign p_mag = scaled_mag(a_mag, b_mag);
  // A product that truncates to zero carries no sign.
  assign p_neg = (a_neg ^ b_neg) && (p_mag != '0);
endmodule

// File: rtl/cmtw_combine.sv
`timescale 1ns/1ps
// Adds or subtracts two sign-magnitude products and repacks the result
// into the sample layout: sign on top, fraction field, then integer field.
module cmtw_combine #(
  parameter int unsigned MW       = 16,
  parameter int unsigned INT_W    = 8,
  parameter bit          SUBTRACT = 1'b0
) (
  input  logic          a_neg,
  input  logic [MW-1:0] a_mag,
  input  logic          b_neg,
  input  logic [MW-1:0] b_mag,
  output logic          r_neg,
  output logic [MW-1:0] r_mag,
  output logic [MW:0]   r_code
);
  localparam int unsigned SW = MW + 2;
  localparam int unsigned FR = MW - INT_W;

  function automatic logic signed [SW-1:0] to_signed(input logic n, input logic [MW-1:0] m);
    logic signed [SW-1:0] v;
    v = $signed({2'b00, m});
    return n ? -v : v;
  endfunction

  function automatic logic [MW:0] pack(input logic n, input logic [MW-1:0] m);
    return {n, m[FR-1:0], m[MW-1:FR]};
  endfunction

  logic signed [SW-1:0] lhs, rhs, total;
  logic        [SW-1:0] total_abs;

  assign lhs = to_signed(a_neg, a_mag);
  assign rhs = to_signed(b_neg, b_mag);

  generate
    if (SUBTRACT) begin : g_sub
      assign total = lhs - rhs;
    end else begin : g_add
      assign total = lhs + rhs;
    end
  endgenerate

  assign total_abs = total[SW-1] ? SW'(-total) : SW'(total);
  assign r_mag     = MW'(total_abs);            // silent wrap above MW bits
  assign r_neg     = total[SW-1] && (r_mag != '0);
  assign r_code    = pack(r_neg, r_mag);
endmodule

// File: rtl/cmtw_twiddle_mul.sv
`timescale 1ns/1ps
module cmtw_twiddle_mul
  import cmtw_pkg::*;
#(
  parameter int unsigned DATA_W = CMTW_DATA_W,
  parameter int unsigned TW_W   = CMTW_TW_W,
  parameter int unsigned INT_W  = CMTW_INT_W
) (
  input  logic [DATA_W-1:0] x_re,
  input  logic [DATA_W-1:0] x_im,
  input  logic [TW_W-1:0]   w_re,
  input  logic [TW_W-1:0]   w_im,
  output logic [DATA_W-1:0] y_re,
  output logic [DATA_W-1:0] y_im
);
  localparam int unsigned MAG_W  = DATA_W - 1;
  localparam int unsigned TMAG_W = TW_W - 1;

  // Index 0 = real part, index 1 = imaginary part.
  logic [1:0][DATA_W-1:0] d_code;
  logic [1:0][TW_W-1:0]   t_code;
  logic [1:0]             d_neg, t_neg;
  logic [1:0][MAG_W-1:0]  d_mag;
  logic [1:0][TMAG_W-1:0] t_mag;

  assign d_code = {x_im, x_re};
  assign t_code = {w_im, w_re};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_dec
      cmtw_part_decode #(.W(DATA_W), .INT_W(INT_W)) u_ddec (
        .code(d_code[g]), .neg(d_neg[g]), .mag(d_mag[g]));
      cmtw_part_decode #(.W(TW_W), .INT_W(0)) u_tdec (
        .code(t_code[g]), .neg(t_neg[g]), .mag(t_mag[g]));
    end
  endgenerate

  // Partial product k = 2*i + j pairs sample part i with coefficient part j:
  // 0 = re*re, 1 = re*im, 2 = im*re, 3 = im*im.
  logic [3:0]            prod_neg;
  logic [3:0][MAG_W-1:0] prod_mag;

  genvar i, j;
  generate
    for (i = 0; i < 2; i++) begin : g_row
      for (j = 0; j < 2; j++) begin : g_col
        cmtw_smul #(.MW(MAG_W), .TW(TMAG_W)) u_mul (
          .a_neg(d_neg[i]), .a_mag(d_mag[i]),
          .b_neg(t_neg[j]), .b_mag(t_mag[j]),
          .p_neg(prod_neg[2*i+j]), .p_mag(prod_mag[2*i+j]));
      end
    end
  endgenerate

  logic [1:0]            res_neg;
  logic [1:0][MAG_W-1:0] res_mag;

  cmtw_combine #(.MW(MAG_W), .INT_W(INT_W), .SUBTRACT(1'b1)) u_real (
    .a_neg(prod_neg[0]), .a_mag(prod_mag[0]),
    .b_neg(prod_neg[3]), .b_mag(prod_mag[3]),
    .r_neg(res_neg[0]), .r_mag(res_mag[0]), .r_code(y_re));

  cmtw_combine #(.MW(MAG_W), .INT_W(INT_W), .SUBTRACT(1'b0)) u_imag (
    .a_neg(prod_neg[1]), .a_mag(prod_mag[1]),
    .b_neg(prod_neg[2]), .b_mag(prod_mag[2]),
    .r_neg(res_neg[1]), .r_mag(res_mag[1]), .r_code(y_im));
endmodule

// File: rtl/cmtw_checker.sv
`timescale 1ns/1ps
module cmtw_checker #(
  parameter int unsigned DATA_W = 17,
  parameter int unsigned TW_W   = 9
) (
  input logic [DATA_W-1:0]            y_re,
  input logic [DATA_W-1:0]            y_im,
  input logic [1:0][DATA_W-2:0]       d_mag,
  input logic [1:0][TW_W-2:0]         t_mag,
  input logic [3:0]                   prod_neg,
  input logic [3:0][DATA_W-2:0]       prod_mag,
  input logic [1:0][DATA_W-2:0]       res_mag
);
  always_comb begin
    if (!$isunknown({y_re, y_im, d_mag, t_mag, prod_neg, prod_mag, res_mag})) begin
      for (int k = 0; k < 4; k++) begin
        AST_PROD_BELOW_DATA: assert ((prod_mag[k] < d_mag[k/2]) || (d_mag[k/2] == '0 && prod_mag[k] == '0)); // R3
        AST_PROD_SIGNED_ZERO: assert (!(prod_neg[k] && prod_mag[k] == '0)); // R5
      end
      AST_NO_NEG_ZERO_RE: assert (!(y_re[DATA_W-1] && res_mag[0] == '0)); // R5
      AST_NO_NEG_ZERO_IM: assert (!(y_im[DATA_W-1] && res_mag[1] == '0)); // R5
      AST_ZERO_TWIDDLE: assert (!(t_mag == '0) || (y_re == '0 && y_im == '0)); // R6
      AST_ZERO_DATA: assert (!(d_mag == '0) || (y_re == '0 && y_im == '0)); // R1 R2
    end
  end
endmodule

bind cmtw_twiddle_mul cmtw_checker #(.DATA_W(DATA_W), .TW_W(TW_W)) u_cmtw_checker (
  .y_re(y_re), .y_im(y_im), .d_mag(d_mag), .t_mag(t_mag),
  .prod_neg(prod_neg), .prod_mag(prod_mag), .res_mag(res_mag));

// File: tb/test_cmtw_twiddle_mul.sv
`timescale 1ns/1ps
module test_cmtw_twiddle_mul;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [16:0] x_re, x_im, y_re, y_im;
  logic [8:0]  w_re, w_im;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cmtw_twiddle_mul i_cmtw_twiddle_mul (
    .x_re(x_re), .x_im(x_im), .w_re(w_re), .w_im(w_im), .y_re(y_re), .y_im(y_im));

  // ---- independent integer model ----
  function automatic int sval(input logic [16:0] c);
    int m;
    m = int'(c[7:0]) * 256 + int'(c[15:8]);
    return c[16] ? -m : m;
  endfunction
  function automatic int wval(input logic [8:0] c);
    return c[8] ? -int'(c[7:0]) : int'(c[7:0]);
  endfunction
  function automatic int pp(input int a, input int b);
    return (a * b) / 256;   // integer division truncates toward zero
  endfunction
  function automatic logic [16:0] enc(input int v);
    int m;
    logic s;
    m = (v < 0) ? -v : v;
    m = m % 65536;
    s = (v < 0) && (m != 0);
    return {s, 8'(m % 256), 8'(m / 256)};
  endfunction
  function automatic logic [16:0] mk(input int v);
    return enc(v);
  endfunction

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (x=%h,%h w=%h,%h)", req, act, exp, x_re, x_im, w_re, w_im);
    end
  endtask

  task automatic apply_and_check(input logic [16:0] a, input logic [16:0] b,
                                 input logic [8:0] c, input logic [8:0] d);
    @(negedge clk);
    x_re = a; x_im = b; w_re = c; w_im = d;
    #1;
    check("R1", y_re, enc(pp(sval(a), wval(c)) - pp(sval(b), wval(d))));
    check("R2", y_im, enc(pp(sval(a), wval(d)) + pp(sval(b), wval(c))));
    if ((y_re[16] && y_re[15:0] == 16'h0) || (y_im[16] && y_im[15:0] == 16'h0)) begin
      checks++; fails++;
      $display("FAIL R5: negative zero actual %h/%h expected no sign on zero", y_re, y_im);
    end
  endtask

  function automatic logic [16:0] rnd_data();
    int v;
    v = int'($urandom_range(0, 32767));
    return mk(($urandom_range(0, 1) != 0) ? -v : v);
  endfunction

  initial begin
    logic [16:0] a, b, ra, ri;
    x_re = '0; x_im = '0; w_re = '0; w_im = '0;
    #1;
    check("R6", y_re, 17'h0);   // all-zero inputs
    check("R6", y_im, 17'h0);

    // R4: 3.5 * 0.5 = 1.75 -> int 1, frac 0xC0
    apply_and_check(17'h08003, 17'h0, 9'h080, 9'h000);
    check("R4", y_re, 17'h0C001);
    // R3: two 255/256 products of opposite sign truncate separately to 0
    apply_and_check(17'h00100, 17'h00100, 9'h0FF, 9'h1FF);
    check("R3", y_re, 17'h0);
    // R3: -3 LSB * 0.5 = -1.5 LSB -> -1 LSB
    apply_and_check(17'h10300, 17'h0, 9'h080, 9'h000);
    check("R3", y_re, 17'h10100);
    // R6: negative-zero coefficient with large sample
    apply_and_check(17'h1ABCD, 17'h05A5A, 9'h100, 9'h100);
    check("R6", y_re, 17'h0);
    check("R6", y_im, 17'h0);
    // R9: magnitude wrap, 65279 + 65279 -> 130558 mod 65536 = 65022
    apply_and_check(17'h0FFFF, 17'h0FFFF, 9'h0FF, 9'h1FF);
    check("R9", y_re, {1'b0, 8'hFE, 8'hFD});
    // R8: input change seen without any clock edge
    @(posedge clk); #2;
    x_re = mk(512); x_im = '0; w_re = 9'h040; w_im = '0;
    #1;
    check("R8", y_re, mk(128));

    // Sweep every real coefficient code against many samples (R1, R2)
    for (int c = 0; c < 512; c++)
      for (int n = 0; n < 48; n++)
        apply_and_check(rnd_data(), rnd_data(), 9'(c), 9'(n * 11));
    // Sweep every imaginary coefficient code
    for (int c = 0; c < 512; c++)
      for (int n = 0; n < 48; n++)
        apply_and_check(rnd_data(), rnd_data(), 9'(n * 11), 9'(c));

    // R7: sign symmetry on random operands
    for (int n = 0; n < 2000; n++) begin
      logic [8:0] wr, wi;
      a = rnd_data(); b = rnd_data();
      wr = 9'($urandom_range(0, 511)); wi = 9'($urandom_range(0, 511));
      apply_and_check(a, b, wr, wi);
      ra = y_re; ri = y_im;
      apply_and_check({~a[16], a[15:0]}, {~b[16], b[15:0]}, wr, wi);
      check("R7", y_re, (ra[15:0] == 16'h0) ? ra : {~ra[16], ra[15:0]});
      check("R7", y_im, (ri[15:0] == 16'h0) ? ri : {~ri[16], ri[15:0]});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule